// File: doc/BRIEF.md
# Converter Serial Readout Sequencer

This block is the digital face of a 16-bit sampling converter. It cycles through three states: converting, sleeping with a result ready, and shifting that result out. A conversion is modelled by a cycle counter of programmable length. When the counter expires, the block captures the word on `sampleIn` and goes to sleep by itself. A host that holds chip select low can read the converter's status on the data line before it applies any serial clock.

The host then clocks the result out, most significant bit first, with either serial clock idle level. The `cpol` input selects the idle level. A new conversion starts in one of two ways: the host raises chip select after clocking, or it applies one more falling clock edge once the last bit has been presented.

`csN` and `sck` are sampled on `clk`. A level change takes effect at the first `clk` rising edge that sees the new level, and the outputs show the result after that edge.

Top module: `adcSerialOut`

## Requirements
- R1: After reset, and after every accepted trigger, `busy` is 1. While `busy` is 1 and `csN` is 0, `sdo` is 1 and `sdoEn` is 1.
- R2: A conversion keeps `busy` high for exactly CONV_CYCLES clock cycles and then drops to sleep with no host action. The word on `sampleIn` in the final conversion cycle is the word that gets shifted out, and later changes of `sampleIn` do not alter it.
- R3: While `csN` is 1, `sdoEn` is 0 and `sdo` is 0 (the line counts as released).
- R4: In sleep, with `csN` at 0 and no leading clock edge since the conversion ended, `sdo` is 0 and `busy` is 0.
- R5: The leading clock edge is rising when `cpol`=0 and falling when `cpol`=1. The k-th leading edge with `csN` at 0 places result bit 16-k on `sdo`, so bit 15 comes first and bit 0 last. During a transfer `sdo` changes only on a leading edge.
- R6: Once all 16 bits have been presented, the next falling `sck` edge with `csN` at 0 starts a conversion. With `cpol`=0 this is the edge that ends the 16th pulse; with `cpol`=1 it is the first edge of a 17th pulse.
- R7: A rising `csN` edge after at least one leading edge starts a conversion. This includes a transfer cut short before bit 0.
- R8: A rising `csN` edge in sleep with no leading edge applied keeps the block asleep with its result intact, and a later transfer returns the full word.
- R9: Edges on `sck` and `csN` during a conversion are ignored. The conversion length is unchanged, and the next transfer starts at bit 15.
- R10: Edges on `sck` while `csN` is 1 in sleep are ignored. No bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; the block leaves reset converting |
| cpol | input | 1 | Serial clock idle level: 0 idle low, 1 idle high |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, oversampled by `clk` |
| sampleIn | input | DATA_W | Result word captured at the end of a conversion |
| sdo | output | 1 | Serial data and status line |
| sdoEn | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| busy | output | 1 | High while a conversion is in progress |

## Verification
The hardest situation to reach is a conversion under a storm of `sck` and `csN` activity. The block must neither restart, shorten nor pre-shift under that activity. The bench triggers a conversion and then toggles `sck` every cycle and flips `csN` every third cycle until `busy` drops. It then checks that the measured length still equals CONV_CYCLES and that the first two bits are bits 15 and 14 of the new word. A second hard case is the difference between the two trigger edges for each `cpol`. Table vectors cover both polarities, with both trigger styles and with aborted transfers.

// File: rtl/adcSerialPkg.sv
package adcSerialPkg;

  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_OUTPUT  = 2'd2
  } adcState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic convClr;   // restart the conversion timer
    logic convStep;  // advance the conversion timer
    logic load;      // capture the sample word
    logic shift;     // move the next bit to the output position
    logic bitClr;    // clear the presented-bit count
    logic bitStep;   // count one presented bit
  } dpStrobe_t;

endpackage

// File: rtl/adcPinSampler.sv
module adcPinSampler #(
  parameter int          WIDTH     = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pinsQ
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinsQ[i] <= RESET_VAL[i];
      else       pinsQ[i] <= pins[i];
    end
  end

endmodule

// File: rtl/adcSerialDatapath.sv
module adcSerialDatapath
  import adcSerialPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              convDone,
  output logic              allSent,
  output logic              msb
);

  localparam int CONV_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [CONV_W-1:0] CONV_LAST = CONV_W'(CONV_CYCLES - 1);
  localparam logic [BIT_W-1:0]  BIT_FULL  = BIT_W'(DATA_W);

  logic [CONV_W-1:0] convCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;

  // Conversion timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                convCnt <= '0;
    else if (strobe.convClr)  convCnt <= '0;
    else if (strobe.convStep) convCnt <= convCnt + 1'b1;
  end

  assign convDone = (convCnt == CONV_LAST);

  // Presented-bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               bitCnt <= '0;
    else if (strobe.bitClr)  bitCnt <= '0;
    else if (strobe.bitStep) bitCnt <= bitCnt + 1'b1;
  end

  assign allSent = (bitCnt == BIT_FULL);

  // Result shifter, MSB at the output position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= sampleIn;
    else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  assign msb = shiftReg[DATA_W-1];

endmodule

// File: rtl/adcSerialCtrl.sv
module adcSerialCtrl
  import adcSerialPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      csRise,
  input  logic      sckLead,
  input  logic      sckFall,
  input  logic      convDone,
  input  logic      allSent,
  output adcState_e state,
  output dpStrobe_t strobe
);

  adcState_e stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_CONVERT: begin
        strobe.convStep = 1'b1;
        if (convDone) begin
          strobe.load   = 1'b1;
          strobe.bitClr = 1'b1;
          stateNext     = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        // A chip-select pulse with no clocking is a status poll only.
        if (!csN && sckLead) begin
          strobe.bitStep = 1'b1;
          stateNext      = ST_OUTPUT;
        end
      end
      ST_OUTPUT: begin
        if (csRise) begin
          strobe.convClr = 1'b1;
          stateNext      = ST_CONVERT;
        end else if (!csN) begin
          if (allSent && sckFall) begin
            strobe.convClr = 1'b1;
            stateNext      = ST_CONVERT;
          end else if (sckLead && !allSent) begin
            strobe.shift   = 1'b1;
            strobe.bitStep = 1'b1;
          end
        end
      end
      default: begin
        strobe.convClr = 1'b1;
        stateNext      = ST_CONVERT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CONVERT;
    else       state <= stateNext;
  end

endmodule

// File: rtl/adcSerialOut.sv
module adcSerialOut
  import adcSerialPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              csN,
  input  logic              sck,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdo,
  output logic              sdoEn,
  output logic              busy
);

  localparam int PIN_CS  = 1;
  localparam int PIN_SCK = 0;

  logic [1:0] pinsQ;
  logic       csRise, sckRise, sckFall, sckLead;
  logic       convDone, allSent, msb, sdoRaw;
  adcState_e  state;
  dpStrobe_t  strobe;

  adcPinSampler #(
    .WIDTH    (2),
    .RESET_VAL(2'b10)
  ) u_sampler (
    .clk  (clk),
    .rstN (rstN),
    .pins ({csN, sck}),
    .pinsQ(pinsQ)
  );

  assign csRise  = csN & ~pinsQ[PIN_CS];
  assign sckRise = sck & ~pinsQ[PIN_SCK];
  assign sckFall = ~sck & pinsQ[PIN_SCK];
  assign sckLead = cpol ? sckFall : sckRise;

  adcSerialCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .csRise  (csRise),
    .sckLead (sckLead),
    .sckFall (sckFall),
    .convDone(convDone),
    .allSent (allSent),
    .state   (state),
    .strobe  (strobe)
  );

  adcSerialDatapath #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sampleIn(sampleIn),
    .convDone(convDone),
    .allSent (allSent),
    .msb     (msb)
  );

  always_comb begin
    unique case (state)
      ST_CONVERT: sdoRaw = 1'b1;
      ST_OUTPUT:  sdoRaw = msb;
      default:    sdoRaw = 1'b0;
    endcase
  end

  assign sdo   = ~csN & sdoRaw;
  assign sdoEn = ~csN;
  assign busy  = (state == ST_CONVERT);

endmodule

// File: rtl/adcSerialOutChk.sv
module adcSerialOutChk #(
  parameter int CONV_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic sdo,
  input logic sdoEn,
  input logic busy
);

  localparam int RUN_W = $clog2(CONV_CYCLES + 2);

  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  AST_STATUS_CONVERTING: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !csN) |-> (sdo && sdoEn)); // R1

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt == RUN_W'(CONV_CYCLES))); // R2

  AST_RELEASED_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sdoEn && !sdo)); // R3

  AST_DATA_HOLDS_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && !csN && $past(!csN) && ($past(sck) == $past(sck, 2)))
      |-> $stable(sdo)); // R5

  AST_RESTART_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (($past(csN) && !$past(csN, 2)) || (!$past(sck) && $past(sck, 2)))); // R7

endmodule

bind adcSerialOut adcSerialOutChk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .csN  (csN),
  .sck  (sck),
  .sdo  (sdo),
  .sdoEn(sdoEn),
  .busy (busy)
);

// File: tb/test_adcSerialOut.sv
module test_adcSerialOut;

  localparam int CONV = 24;

  typedef struct packed {
    logic        cpolV;
    logic        sckMode;  // 1: trigger by falling clock edge, 0: by chip-select rise
    logic [4:0]  nBits;
    logic [15:0] word;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    vec_t'{1'b0, 1'b0, 5'd16, 16'hA5C3},
    vec_t'{1'b0, 1'b1, 5'd16, 16'h1234},
    vec_t'{1'b1, 1'b0, 5'd16, 16'h8001},
    vec_t'{1'b1, 1'b1, 5'd16, 16'h7FFE},
    vec_t'{1'b0, 1'b0, 5'd5,  16'h0F0F},
    vec_t'{1'b1, 1'b0, 5'd1,  16'hC0DE}
  };
  localparam logic [15:0] DIR_WORD_A = 16'h3C96;
  localparam logic [15:0] DIR_WORD_B = 16'h9A5B;

  logic        clk = 1'b0;
  logic        rstN, cpol, csN, sck;
  logic [15:0] sampleIn;
  logic        sdo, sdoEn, busy;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  adcSerialOut #(.DATA_W(16), .CONV_CYCLES(CONV)) i_adcSerialOut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .csN(csN), .sck(sck),
    .sampleIn(sampleIn), .sdo(sdo), .sdoEn(sdoEn), .busy(busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkNum(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Count samples with busy high after a trigger driven at the current negedge.
  task automatic measureConv(input logic [15:0] nextWord, input bit dropCs,
                             input bit storm, output int cnt);
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (!busy) break;
      cnt++;
      if (cnt == 1) sampleIn = nextWord;
      if (storm) begin
        sck = ~sck;
        if (cnt % 3 == 0) csN = ~csN;
      end else begin
        if (cnt == 2) sck = cpol;
        if (cnt == 3 && dropCs) begin
          checkBit("R1 status while converting", sdo, 1'b1);
          checkBit("R1 enable while converting", sdoEn, 1'b1);
          csN = 1'b1;  // R9: chip-select rise during conversion
        end
      end
    end
  endtask

  task automatic runVector(input int v);
    vec_t cv;
    logic [15:0] nxt;
    int cnt;
    cv  = VEC[v];
    nxt = (v == NVEC - 1) ? DIR_WORD_A : VEC[v+1].word;
    cpol = cv.cpolV;
    sck  = cv.cpolV;
    tick();
    csN = 1'b0;
    tick();
    checkBit("R4 sdo low in sleep", sdo, 1'b0);
    checkBit("R4 not busy in sleep", busy, 1'b0);
    for (int k = 1; k <= int'(cv.nBits); k++) begin
      sck = ~cv.cpolV;
      tick();
      checkBit("R5 data bit", sdo, cv.word[16-k]);
      if (k < int'(cv.nBits)) begin
        sck = cv.cpolV;
        tick();
      end
    end
    if (!cv.sckMode) begin
      if (cv.cpolV) begin sck = 1'b1; tick(); end
      csN = 1'b1;                       // R7 trigger
    end else if (cv.cpolV) begin
      sck = 1'b1; tick();
      sck = 1'b0;                       // R6: falling edge of 17th pulse
    end else begin
      sck = 1'b0;                       // R6: falling edge ending 16th pulse
    end
    measureConv(nxt, cv.sckMode, 1'b0, cnt);
    if (cv.sckMode) checkNum("R6 restart by clock edge", cnt, CONV);
    else            checkNum("R7 restart by chip-select rise", cnt, CONV);
    checkNum("R2 conversion length", cnt, CONV);
    checkBit("R3 released when deselected", sdoEn, 1'b0);
    checkBit("R3 sdo low when deselected", sdo, 1'b0);
  endtask

  initial begin
    logic [15:0] got;
    int cnt;
    rstN = 1'b0; cpol = 1'b0; csN = 1'b1; sck = 1'b0;
    sampleIn = VEC[0].word;
    repeat (3) tick();
    rstN = 1'b1;
    checkBit("R1 busy after reset", busy, 1'b1);
    checkBit("R3 enable off after reset", sdoEn, 1'b0);
    csN = 1'b0;
    tick();
    checkBit("R1 status high after reset", sdo, 1'b1);
    csN = 1'b1;
    for (int i = 0; i < 1000 && busy; i++) tick();
    checkBit("R2 sleeps on its own", busy, 1'b0);

    for (int v = 0; v < NVEC; v++) runVector(v);

    // R8: status poll in sleep without clocks keeps the result.
    csN = 1'b0; tick();
    checkBit("R8 poll shows ready", sdo, 1'b0);
    csN = 1'b1; tick();
    checkBit("R8 still asleep after poll", busy, 1'b0);
    sampleIn = 16'hFFFF;  // R2: must not reach the captured word
    // R10: clock edges while deselected
    for (int i = 0; i < 4; i++) begin sck = ~sck; tick(); end
    csN = 1'b0; tick();
    checkBit("R10 no bit consumed while deselected", sdo, 1'b0);
    got = '0;
    for (int k = 1; k <= 16; k++) begin
      sck = 1'b0; tick();
      got[16-k] = sdo;
      sck = 1'b1; tick();
    end
    checkNum("R8 full word after poll", int'(got), int'(DIR_WORD_A));
    checkNum("R2 captured word held", int'(got), int'(DIR_WORD_A));

    // R9: heavy activity during a conversion
    csN = 1'b1;
    measureConv(DIR_WORD_B, 1'b0, 1'b1, cnt);
    checkNum("R9 length under activity", cnt, CONV);
    csN = 1'b1; sck = cpol; tick(); tick();
    csN = 1'b0; tick();
    checkBit("R9 nothing pre-shifted", sdo, 1'b0);
    sck = ~cpol; tick();
    checkBit("R9 first bit is bit 15", sdo, DIR_WORD_B[15]);
    sck = cpol; tick();
    sck = ~cpol; tick();
    checkBit("R9 second bit is bit 14", sdo, DIR_WORD_B[14]);
    csN = 1'b1; tick();
    checkBit("R7 abort restarts", busy, 1'b1);
    repeat (2) tick();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule